// File: doc/BRIEF.md
# Smart Card Reset Release Sequencer

This block owns the active-low reset line of a smart card. It holds the line low while the card supply is not good or while firmware asks for the card to be held in reset. Once both conditions clear, it lets the line go high after a programmable number of elementary time units (ETUs). Each ETU is marked by a one-cycle tick from a divider outside the block. On the clock edge where the line goes high, the block emits a one-cycle pulse that a downstream timer can use to start timing the card's first answer character.

The delay arrives as an 8-bit value from a configuration register kept elsewhere. That register conventionally resets to 0x70, which is 112 ETUs. The block captures the value when a countdown starts. A delay of zero releases the line on the first edge at which the supply is good and no hold is requested. Firmware can set the hold before power is applied. It can then power the card and keep it in reset for as long as it needs. Clearing the hold starts the full delay.

Top module: `sc_rst_seq`

## Requirements
- R1: When `supply_ok` is sampled low at an edge, `card_rst_n` is 0 after that edge. A countdown in progress is discarded, and the next release needs the full delay again.
- R2: When `hold_req` is sampled high at an edge, `card_rst_n` is 0 after that edge, including when the line was already released.
- R3: With `delay_len` = 0, `card_rst_n` becomes 1 at the first edge that samples `supply_ok`=1 and `hold_req`=0.
- R4: With `delay_len` = D > 0, the release edge is found as follows. Let E0 be the first edge that samples `supply_ok`=1 and `hold_req`=0. `card_rst_n` becomes 1 at the edge sampling the D-th `etu_tick` after E0. A tick sampled at E0 itself is not counted, and the line stays 0 before the release edge.
- R5: If `hold_req` is 1 before and while supply becomes good, `card_rst_n` stays 0 for as long as the hold stays set, whatever ticks arrive. Once the hold is cleared, release follows the rule of R3 or R4, with E0 taken at the clearing.
- R6: Setting `hold_req` during a pending countdown cancels it. After the hold is cleared, the full delay is counted again from the new E0.
- R7: `release_pulse` is 1 for exactly the one cycle following the edge where `card_rst_n` goes from 0 to 1, and 0 at all other times.
- R8: `delay_len` is captured at E0. Changing it during a countdown, or while the line is released, does not change the release timing or the output.
- R9: While `rst` is 1 and after it ends, `card_rst_n` is 0 and `release_pulse` is 0 until a release condition arises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| etu_tick | input | 1 | One-cycle pulse per elementary time unit |
| supply_ok | input | 1 | Card supply is within range |
| hold_req | input | 1 | Firmware request to keep the card in reset |
| delay_len | input | DLY_W (8) | Release delay in ETUs; 0 means no delay |
| card_rst_n | output | 1 | Card reset pin level, registered, low = reset |
| release_pulse | output | 1 | One-cycle pulse on the edge where `card_rst_n` rises |

## Verification
A state register stuck in the waiting state would show as a pin that never rises. A lost abort would let the pin rise with the supply gone; the bench catches either within one cycle of the expected edge. An off-by-one in the ETU countdown moves the rising edge by a whole tick period. A captured delay that tracks the live input moves it by many ticks. The bench checks the pin every cycle, so it catches these at the first mismatching cycle. A pulse decoder out of step with the pin shows as a pulse without a rise, or a rise without a pulse, on the same cycle.

// File: rtl/sc_rst_pkg.sv
package sc_rst_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAIT = 2'd1,
    ST_ON   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/sc_rst_gate.sv
module sc_rst_gate #(
  parameter int DLY_W = 8
) (
  input  logic             supply_ok,
  input  logic             hold_req,
  input  logic [DLY_W-1:0] delay_len,
  output logic             go,
  output logic             zero_dly
);
  // Release is allowed only with good supply and no firmware hold
  assign go       = supply_ok & ~hold_req;
  assign zero_dly = (delay_len == '0);
endmodule

// File: rtl/sc_rst_etu_cnt.sv
module sc_rst_etu_cnt #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick && cnt != '0) begin
      cnt <= cnt - ONE;
    end
  end

  // The last tick of the countdown
  assign expire = tick && !load && (cnt == ONE);
endmodule

// File: rtl/sc_rst_fsm.sv
module sc_rst_fsm
  import sc_rst_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic zero_dly,
  input  logic expire,
  output logic load,
  output logic clr,
  output logic next_on,
  output logic rise
);
  seq_state_t state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_OFF:  if (go) nxt = zero_dly ? ST_ON : ST_WAIT;
      ST_WAIT: if (!go) nxt = ST_OFF;
               else if (expire) nxt = ST_ON;
      ST_ON:   if (!go) nxt = ST_OFF;
      default: nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_OFF;
    else     state <= nxt;
  end

  assign load    = (state == ST_OFF) && go && !zero_dly;
  assign clr     = !go;
  assign next_on = (nxt == ST_ON);
  assign rise    = next_on && (state != ST_ON);
endmodule

// File: rtl/sc_rst_seq.sv
module sc_rst_seq #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             etu_tick,
  input  logic             supply_ok,
  input  logic             hold_req,
  input  logic [DLY_W-1:0] delay_len,
  output logic             card_rst_n,
  output logic             release_pulse
);
  logic go, zero_dly, expire, load, clr, next_on, rise;

  sc_rst_gate #(.DLY_W(DLY_W)) u_gate (
    .supply_ok (supply_ok),
    .hold_req  (hold_req),
    .delay_len (delay_len),
    .go        (go),
    .zero_dly  (zero_dly)
  );

  sc_rst_etu_cnt #(.DLY_W(DLY_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .load     (load),
    .load_val (delay_len),
    .tick     (etu_tick),
    .expire   (expire)
  );

  sc_rst_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .zero_dly (zero_dly),
    .expire   (expire),
    .load     (load),
    .clr      (clr),
    .next_on  (next_on),
    .rise     (rise)
  );

  // Registered pin and pulse, aligned with the state register
  always_ff @(posedge clk) begin
    if (rst) begin
      card_rst_n    <= 1'b0;
      release_pulse <= 1'b0;
    end else begin
      card_rst_n    <= next_on;
      release_pulse <= rise;
    end
  end
endmodule

// File: rtl/sc_rst_seq_chk.sv
module sc_rst_seq_chk (
  input logic clk,
  input logic rst,
  input logic supply_ok,
  input logic hold_req,
  input logic card_rst_n,
  input logic release_pulse
);
  // R1: supply loss forces reset low
  a_r1_supply_loss: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> !card_rst_n);

  // R2: firmware hold forces reset low
  a_r2_hold_low: assert property (@(posedge clk) disable iff (rst)
    hold_req |=> !card_rst_n);

  // R3/R4: a rise needs supply good and no hold at that edge
  a_r4_rise_needs_go: assert property (@(posedge clk) disable iff (rst)
    $rose(card_rst_n) |-> $past(supply_ok && !hold_req));

  // R7: every rise carries a pulse
  a_r7_pulse_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(card_rst_n) |-> release_pulse);

  // R7: a pulse only with a rise
  a_r7_pulse_only_rise: assert property (@(posedge clk) disable iff (rst)
    release_pulse |-> $rose(card_rst_n));
endmodule

bind sc_rst_seq sc_rst_seq_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .supply_ok     (supply_ok),
  .hold_req      (hold_req),
  .card_rst_n    (card_rst_n),
  .release_pulse (release_pulse)
);

// File: tb/sim_sc_rst_seq.sv
module sim_sc_rst_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       etu_tick = 1'b0;
  logic       supply_ok = 1'b0;
  logic       hold_req = 1'b0;
  logic [7:0] delay_len = 8'h70;
  logic       card_rst_n, release_pulse;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sc_rst_seq #(.DLY_W(8)) u0 (
    .clk(clk), .rst(rst), .etu_tick(etu_tick), .supply_ok(supply_ok),
    .hold_req(hold_req), .delay_len(delay_len),
    .card_rst_n(card_rst_n), .release_pulse(release_pulse)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, got, exp);
    end
  endtask

  // Called at a falling edge: apply tick, pass one rising edge, return at next falling edge
  task automatic step(input logic tk);
    etu_tick = tk;
    @(posedge clk);
    @(negedge clk);
    etu_tick = 1'b0;
  endtask

  // Edge j=0 is the first edge seeing release allowed; tick every P edges
  task automatic countdown(input int d, input int p, input int stop_at,
                           input bit chg, input string tag);
    int last;
    last = (stop_at >= 0) ? stop_at : d * p + 2;
    for (int j = 0; j <= last; j++) begin
      if (chg && j == 1) delay_len = delay_len ^ 8'h5A; // R8: late change ignored
      step(j > 0 && (j % p) == 0);
      chk(tag, card_rst_n, (j >= d * p));
      chk("R7", release_pulse, (j == d * p));
    end
  endtask

  task automatic power_off(input int d, input bit pre_hold);
    supply_ok = 1'b0;
    hold_req  = pre_hold;
    delay_len = 8'(d);
    for (int k = 0; k < 3; k++) begin
      step(1'b1);
      chk("R1", card_rst_n, 1'b0);
      chk("R7", release_pulse, 1'b0);
    end
  endtask

  task automatic run_seq(input int d, input int p, input bit pre_hold, input bit chg);
    string tag;
    tag = chg ? "R8" : (pre_hold ? "R5" : (d == 0 ? "R3" : "R4"));
    power_off(d, pre_hold);
    supply_ok = 1'b1;
    if (pre_hold) begin
      for (int k = 0; k < 5; k++) begin
        step(1'b1);
        chk("R5", card_rst_n, 1'b0);
      end
      hold_req = 1'b0;
    end
    countdown(d, p, -1, chg, tag);
    // R8: delay change while released has no effect
    delay_len = 8'h00;
    step(1'b1);
    chk("R8", card_rst_n, 1'b1);
    chk("R7", release_pulse, 1'b0);
    // R2: hold drops a released line on the next edge
    hold_req = 1'b1;
    step(1'b0);
    chk("R2", card_rst_n, 1'b0);
    chk("R7", release_pulse, 1'b0);
    hold_req = 1'b0;
    supply_ok = 1'b0;
    step(1'b0);
  endtask

  // Abort a pending countdown halfway, then expect a full restart
  task automatic run_abort(input int d, input int p, input bit by_hold);
    string tag;
    tag = by_hold ? "R6" : "R1";
    power_off(d, 1'b0);
    supply_ok = 1'b1;
    countdown(d, p, (d * p) / 2, 1'b0, tag);
    if (by_hold) hold_req = 1'b1;
    else         supply_ok = 1'b0;
    for (int k = 0; k < 2; k++) begin
      step(1'b1);
      chk(tag, card_rst_n, 1'b0);
      chk("R7", release_pulse, 1'b0);
    end
    hold_req  = 1'b0;
    supply_ok = 1'b1;
    countdown(d, p, -1, 1'b0, tag);
    supply_ok = 1'b0;
    step(1'b0);
  endtask

  initial begin
    @(negedge clk);
    supply_ok = 1'b1;
    delay_len = 8'h00;
    for (int k = 0; k < 4; k++) begin
      step(1'b1);
      chk("R9", card_rst_n, 1'b0);
      chk("R9", release_pulse, 1'b0);
    end
    supply_ok = 1'b0;
    rst = 1'b0;
    step(1'b0);
    chk("R9", card_rst_n, 1'b0);
    chk("R9", release_pulse, 1'b0);

    for (int d = 0; d <= 6; d++)
      for (int p = 1; p <= 3; p++)
        for (int h = 0; h <= 1; h++)
          for (int c = 0; c <= 1; c++)
            if (!(c == 1 && d == 0)) run_seq(d, p, h[0], c[0]);
    run_seq(255, 1, 1'b0, 1'b0);
    run_seq(255, 2, 1'b1, 1'b1);
    run_seq(8'h70, 1, 1'b0, 1'b0);

    for (int d = 2; d <= 6; d++)
      for (int p = 1; p <= 2; p++) begin
        run_abort(d, p, 1'b1);
        run_abort(d, p, 1'b0);
      end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(20ns * 200000);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule